// File: doc/BRIEF.md
# Command-list I2C transfer sequencer

This block sits between a register port and a byte-level I2C bit engine. Software fills up to sixteen 8-bit command slots, each an encoded operation: bus start, bus stop, byte write, byte read, no-acknowledge on read, and a 3-bit repeat field. It then writes the go register. The sequencer walks the slots from slot 0 and hands each operation to the bit engine over a request/done handshake. For a write it takes the transmit byte from the slot after the command. Received bytes are packed little-endian into a 16-byte receive buffer that is read as four 32-bit words.

The walk ends at the first all-zero slot, after the last slot, or at a write command that has no data slot left. At that point a command-done flag is set. A write that the addressed device does not acknowledge aborts the walk. The sequencer then sends a stop-only operation and raises error and no-acknowledge flags instead of command done. Either flag can drive the interrupt output through its own enable. A self-clearing soft reset returns every register and buffer to zero.

Top module: `i2c_cmd_seq`

## Requirements
- R1: Command slot k is written and read at address 0x30+4k, low 8 bits, with the other bits reading 0. Writes to slots while the sequencer is busy are ignored.
- R2: Writing 1 to bit 0 of the go register (0x1C) starts a walk from slot 0, but only when the sequencer is idle and control bits 1 (enable) and 2 (master) are both set; otherwise the write is ignored. Writing 0 clears the go bit, and the go bit reads back at bit 0.
- R3: Each executed slot is issued once to the engine with eng_cmd_o equal to the slot word. Slot bit 4 marks a write: eng_tx_o then carries the next slot and the walk advances by two slots. Otherwise eng_tx_o is 0 and the walk advances by one.
- R4: The walk ends at an all-zero slot, when the index reaches 16, or at a write in slot 15. On ending it sets status bit 8 (command done) and clears status bit 0 (busy).
- R5: Slot bit 5 marks a read. The i-th byte received in a walk is stored at bits 8*(i%4)+7:8*(i%4) of the word at 0x80+4*(i/4). The receive buffer is cleared when a walk starts.
- R6: A write completed with eng_ack_i low aborts the walk. The sequencer then issues the stop-only operation 0x40 and, when it completes, sets status bits 9 (error) and 2 (no-acknowledge) but not bit 8. The slot index stays on the failing slot.
- R7: The status register at 0x0C has these fields: bit 0 busy; bit 1 engine request outstanding; bit 6 set when an operation with slot bit 6 (stop) or the abort stop completes, cleared at walk start; bits 20:16 the current slot index.
- R8: Writing 1 to status bits 2, 8 or 9 clears that flag. A hardware set in the same cycle wins over the clear.
- R9: irq_o is high when (bit 8 and control bit 11) or (bit 9 and control bit 12) are set, and status bit 4 mirrors irq_o.
- R10: Writing 1 to control bit 0 (0x10) starts a soft reset. That bit reads 1 for RST_CYCLES cycles and then 0, and every register, slot and receive byte returns to 0 and any walk stops.
- R11: eng_req_o, once raised, stays high until the engine answers with eng_done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| irq_o | output | 1 | Interrupt request |
| eng_req_o | output | 1 | Operation request to the bit engine |
| eng_cmd_o | output | 8 | Operation command word |
| eng_tx_o | output | 8 | Byte to transmit on a write operation |
| eng_done_i | input | 1 | Engine completion pulse |
| eng_ack_i | input | 1 | Acknowledge received, valid with eng_done_i |
| eng_rx_i | input | 8 | Received byte, valid with eng_done_i |

## Verification
The end of a walk, where the hardware sets command done, can land in the same cycle as a software write-one-to-clear of that flag. The bench sets this up from the cycle in which the engine answers the last operation. It then times the status write so that it is sampled on the very edge where the sequencer finds the empty slot that follows. After that, command done must still read 1 and a later plain clear must take effect. A no-acknowledge abort is also provoked, and its stop operation and flags are judged against the scoreboard.

// File: rtl/i2c_cmd_seq_pkg.sv
package i2c_cmd_seq_pkg;
  localparam int unsigned CB_START = 7;
  localparam int unsigned CB_STOP  = 6;
  localparam int unsigned CB_RD    = 5;
  localparam int unsigned CB_WR    = 4;

  localparam logic [7:0] ADR_STATUS = 8'h0C;
  localparam logic [7:0] ADR_CTRL   = 8'h10;
  localparam logic [7:0] ADR_GO     = 8'h1C;
  localparam logic [7:0] ADR_CMD    = 8'h30;
  localparam logic [7:0] ADR_DATA   = 8'h80;

  localparam logic [7:0] OP_STOP_ONLY = 8'h40;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC, ST_ABORT} seq_state_e;
endpackage

// File: rtl/i2c_cmd_seq_rxbuf.sv
module i2c_cmd_seq_rxbuf #(
  parameter int unsigned RX_BYTES = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  we_i,
  input  logic [7:0]            byte_i,
  output logic [RX_BYTES*8-1:0] bytes_o
);
  localparam int unsigned CNT_W = $clog2(RX_BYTES);

  logic [CNT_W-1:0] wr_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wr_idx <= '0;
    else if (clr_i)   wr_idx <= '0;
    else if (we_i)    wr_idx <= wr_idx + CNT_W'(1);
  end

  for (genvar g = 0; g < RX_BYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              byte_q <= '0;
      else if (clr_i)                           byte_q <= '0;
      else if (we_i && wr_idx == CNT_W'(g))     byte_q <= byte_i;
    end
    assign bytes_o[g*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/i2c_cmd_seq_fsm.sv
module i2c_cmd_seq_fsm
  import i2c_cmd_seq_pkg::*;
#(
  parameter int unsigned SLOTS = 16,
  localparam int unsigned PTR_W = $clog2(SLOTS) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             go_i,
  input  logic [7:0]       cur_cmd_i,
  input  logic [7:0]       nxt_cmd_i,
  input  logic             eng_done_i,
  input  logic             eng_ack_i,
  input  logic [7:0]       eng_rx_i,
  output logic             eng_req_o,
  output logic [7:0]       eng_cmd_o,
  output logic [7:0]       eng_tx_o,
  output logic             busy_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             done_set_o,
  output logic             err_set_o,
  output logic             stop_set_o,
  output logic             rx_we_o,
  output logic [7:0]       rx_byte_o
);
  seq_state_e state_q;
  logic [PTR_W-1:0] ptr_q;
  logic is_wr, is_rd, walk_end, wr_nack;

  assign is_wr    = cur_cmd_i[CB_WR];
  assign is_rd    = cur_cmd_i[CB_RD];
  assign walk_end = (ptr_q == PTR_W'(SLOTS)) || (cur_cmd_i == 8'h00) ||
                    (is_wr && ptr_q == PTR_W'(SLOTS - 1));
  assign wr_nack  = is_wr && !eng_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
    end else if (clr_i) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (go_i) begin
                    ptr_q   <= '0;
                    state_q <= ST_FETCH;
                  end
        ST_FETCH: state_q <= walk_end ? ST_IDLE : ST_EXEC;
        ST_EXEC:  if (eng_done_i) begin
                    if (wr_nack) state_q <= ST_ABORT;
                    else begin
                      ptr_q   <= ptr_q + (is_wr ? PTR_W'(2) : PTR_W'(1));
                      state_q <= ST_FETCH;
                    end
                  end
        ST_ABORT: if (eng_done_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign eng_req_o  = (state_q == ST_EXEC) || (state_q == ST_ABORT);
  assign eng_cmd_o  = (state_q == ST_ABORT) ? OP_STOP_ONLY : cur_cmd_i;
  assign eng_tx_o   = (state_q == ST_EXEC && is_wr) ? nxt_cmd_i : 8'h00;
  assign busy_o     = (state_q != ST_IDLE);
  assign ptr_o      = ptr_q;
  assign done_set_o = (state_q == ST_FETCH) && walk_end;
  assign err_set_o  = (state_q == ST_ABORT) && eng_done_i;
  assign stop_set_o = eng_done_i && ((state_q == ST_ABORT) ||
                      (state_q == ST_EXEC && cur_cmd_i[CB_STOP]));
  assign rx_we_o    = (state_q == ST_EXEC) && eng_done_i && is_rd;
  assign rx_byte_o  = eng_rx_i;
endmodule

// File: rtl/i2c_cmd_seq_regs.sv
module i2c_cmd_seq_regs
  import i2c_cmd_seq_pkg::*;
#(
  parameter int unsigned SLOTS      = 16,
  parameter int unsigned RX_BYTES   = 16,
  parameter int unsigned RST_CYCLES = 4,
  localparam int unsigned PTR_W = $clog2(SLOTS) + 1,
  localparam int unsigned IDX_W = $clog2(SLOTS),
  localparam int unsigned RC_W  = $clog2(RST_CYCLES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_wr_i,
  input  logic [7:0]            reg_addr_i,
  input  logic [31:0]           reg_wdata_i,
  output logic [31:0]           reg_rdata_o,
  input  logic                  busy_i,
  input  logic                  tip_i,
  input  logic [PTR_W-1:0]      ptr_i,
  input  logic                  done_set_i,
  input  logic                  err_set_i,
  input  logic                  stop_set_i,
  input  logic [RX_BYTES*8-1:0] rx_bytes_i,
  output logic                  go_o,
  output logic                  srst_o,
  output logic [7:0]            cur_cmd_o,
  output logic [7:0]            nxt_cmd_o,
  output logic                  done_flag_o,
  output logic                  err_flag_o,
  output logic                  irq_o
);
  logic [RC_W-1:0] rst_cnt;
  logic en_q, master_q, done_ie_q, err_ie_q, go_q;
  logic done_q, err_q, nack_q, stop_q;
  logic [7:0] cmd_q [SLOTS];
  logic [7:0] cmd_off, data_off;
  logic cmd_hit, data_hit, wr_ctrl, wr_stat, wr_go;
  logic [IDX_W-1:0] cmd_idx, nxt_idx;
  logic [31:0] status;

  wire unused_wdata = ^{reg_wdata_i[31:13], reg_wdata_i[10], reg_wdata_i[7:3]};

  assign srst_o   = (rst_cnt != '0);
  assign cmd_off  = reg_addr_i - ADR_CMD;
  assign data_off = reg_addr_i - ADR_DATA;
  assign cmd_hit  = (reg_addr_i >= ADR_CMD) && (cmd_off < 8'(4 * SLOTS)) && (reg_addr_i[1:0] == 2'b00);
  assign data_hit = (reg_addr_i >= ADR_DATA) && (data_off < 8'(RX_BYTES)) && (reg_addr_i[1:0] == 2'b00);
  assign cmd_idx  = cmd_off[IDX_W+1:2];
  assign wr_ctrl  = reg_wr_i && !srst_o && reg_addr_i == ADR_CTRL;
  assign wr_stat  = reg_wr_i && !srst_o && reg_addr_i == ADR_STATUS;
  assign wr_go    = reg_wr_i && !srst_o && reg_addr_i == ADR_GO;
  assign go_o     = wr_go && reg_wdata_i[0] && !busy_i && en_q && master_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rst_cnt <= '0;
    else if (srst_o)                      rst_cnt <= rst_cnt - RC_W'(1);
    else if (wr_ctrl && reg_wdata_i[0])   rst_cnt <= RC_W'(RST_CYCLES);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || srst_o) begin
      {en_q, master_q, done_ie_q, err_ie_q, go_q} <= '0;
      {done_q, err_q, nack_q, stop_q} <= '0;
    end else begin
      if (wr_ctrl && !reg_wdata_i[0]) begin
        en_q      <= reg_wdata_i[1];
        master_q  <= reg_wdata_i[2];
        done_ie_q <= reg_wdata_i[11];
        err_ie_q  <= reg_wdata_i[12];
      end
      if (wr_go && !reg_wdata_i[0]) go_q <= 1'b0;
      else if (go_o)                go_q <= 1'b1;
      // hardware set takes priority over write-one-to-clear
      if (done_set_i)                        done_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[8])    done_q <= 1'b0;
      if (err_set_i)                         err_q  <= 1'b1;
      else if (wr_stat && reg_wdata_i[9])    err_q  <= 1'b0;
      if (err_set_i)                         nack_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[2])    nack_q <= 1'b0;
      if (go_o)                              stop_q <= 1'b0;
      else if (stop_set_i)                   stop_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cmd_q[g] <= '0;
      else if (srst_o)  cmd_q[g] <= '0;
      else if (reg_wr_i && cmd_hit && !busy_i && cmd_idx == IDX_W'(g))
        cmd_q[g] <= reg_wdata_i[7:0];
    end
  end

  assign nxt_idx   = ptr_i[IDX_W-1:0] + IDX_W'(1);
  assign cur_cmd_o = cmd_q[ptr_i[IDX_W-1:0]];
  assign nxt_cmd_o = cmd_q[nxt_idx];

  assign irq_o       = (done_q && done_ie_q) || (err_q && err_ie_q);
  assign done_flag_o = done_q;
  assign err_flag_o  = err_q;

  always_comb begin
    status            = '0;
    status[0]         = busy_i;
    status[1]         = tip_i;
    status[2]         = nack_q;
    status[4]         = irq_o;
    status[6]         = stop_q;
    status[8]         = done_q;
    status[9]         = err_q;
    status[16 +: PTR_W] = ptr_i;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADR_STATUS)      reg_rdata_o = status;
    else if (reg_addr_i == ADR_CTRL) begin
      reg_rdata_o[0]  = srst_o;
      reg_rdata_o[1]  = en_q;
      reg_rdata_o[2]  = master_q;
      reg_rdata_o[11] = done_ie_q;
      reg_rdata_o[12] = err_ie_q;
    end
    else if (reg_addr_i == ADR_GO)     reg_rdata_o[0] = go_q;
    else if (cmd_hit)                  reg_rdata_o[7:0] = cmd_q[cmd_idx];
    else if (data_hit)                 reg_rdata_o = rx_bytes_i[data_off[7:2]*32 +: 32];
  end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_cmd_seq_pkg::*;
#(
  parameter int unsigned SLOTS      = 16,
  parameter int unsigned RX_BYTES   = 16,
  parameter int unsigned RST_CYCLES = 4,
  localparam int unsigned PTR_W = $clog2(SLOTS) + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o,
  output logic        eng_req_o,
  output logic [7:0]  eng_cmd_o,
  output logic [7:0]  eng_tx_o,
  input  logic        eng_done_i,
  input  logic        eng_ack_i,
  input  logic [7:0]  eng_rx_i
);
  logic go, srst, busy, tip;
  logic done_set, err_set, stop_set, rx_we;
  logic done_flag, err_flag;
  logic [7:0] cur_cmd, nxt_cmd, rx_byte;
  logic [PTR_W-1:0] ptr;
  logic [RX_BYTES*8-1:0] rx_bytes;

  assign tip = eng_req_o;

  i2c_cmd_seq_regs #(.SLOTS(SLOTS), .RX_BYTES(RX_BYTES), .RST_CYCLES(RST_CYCLES)) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .tip_i(tip), .ptr_i(ptr),
    .done_set_i(done_set), .err_set_i(err_set), .stop_set_i(stop_set),
    .rx_bytes_i(rx_bytes), .go_o(go), .srst_o(srst),
    .cur_cmd_o(cur_cmd), .nxt_cmd_o(nxt_cmd),
    .done_flag_o(done_flag), .err_flag_o(err_flag), .irq_o
  );

  i2c_cmd_seq_fsm #(.SLOTS(SLOTS)) u_fsm (
    .clk_i, .rst_ni, .clr_i(srst), .go_i(go),
    .cur_cmd_i(cur_cmd), .nxt_cmd_i(nxt_cmd),
    .eng_done_i, .eng_ack_i, .eng_rx_i,
    .eng_req_o, .eng_cmd_o, .eng_tx_o,
    .busy_o(busy), .ptr_o(ptr),
    .done_set_o(done_set), .err_set_o(err_set), .stop_set_o(stop_set),
    .rx_we_o(rx_we), .rx_byte_o(rx_byte)
  );

  i2c_cmd_seq_rxbuf #(.RX_BYTES(RX_BYTES)) u_rxbuf (
    .clk_i, .rst_ni, .clr_i(go || srst), .we_i(rx_we), .byte_i(rx_byte),
    .bytes_o(rx_bytes)
  );
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk
  import i2c_cmd_seq_pkg::*;
#(
  parameter int unsigned SLOTS = 16,
  localparam int unsigned PTR_W = $clog2(SLOTS) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy,
  input logic             srst,
  input logic             done_flag,
  input logic             err_flag,
  input logic [PTR_W-1:0] ptr,
  input logic             reg_wr_i,
  input logic [7:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic             eng_req_o,
  input logic [7:0]       eng_cmd_o,
  input logic             eng_done_i
);
  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || srst)
    eng_req_o && !eng_done_i |=> eng_req_o);
  // R4
  fin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (done_flag || err_flag || $past(srst)));
  // R6
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || srst)
    $rose(err_flag) |-> $past(eng_req_o && eng_done_i && eng_cmd_o == OP_STOP_ONLY));
  // R2
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(reg_wr_i && reg_addr_i == ADR_GO && reg_wdata_i[0]));
  // R7
  ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> ptr <= PTR_W'(SLOTS));
  // R10
  srst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> !busy);
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk #(.SLOTS(SLOTS)) u_chk (
  .clk_i, .rst_ni, .busy, .srst, .done_flag, .err_flag, .ptr,
  .reg_wr_i, .reg_addr_i, .reg_wdata_i, .eng_req_o, .eng_cmd_o, .eng_done_i
);

// File: tb/i2c_cmd_seq_test.sv
module i2c_cmd_seq_test;
  localparam logic [7:0] A_ST = 8'h0C, A_CT = 8'h10, A_GO = 8'h1C, A_DT = 8'h80;
  localparam logic [31:0] CT_RUN = 32'h0000_1806;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, eng_req, eng_done = 1'b0, eng_ack = 1'b1;
  logic [7:0]  eng_cmd, eng_tx, eng_rx = '0;

  i2c_cmd_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .eng_req_o(eng_req), .eng_cmd_o(eng_cmd), .eng_tx_o(eng_tx),
    .eng_done_i(eng_done), .eng_ack_i(eng_ack), .eng_rx_i(eng_rx)
  );

  typedef struct {logic [7:0] cmd; logic [7:0] tx; logic ack; logic [7:0] rx;} op_t;
  op_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic push(input logic [7:0] c, input logic [7:0] t, input logic a, input logic [7:0] r);
    op_t o;
    o.cmd = c; o.tx = t; o.ack = a; o.rx = r;
    exp_q.push_back(o);
  endtask

  // engine model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (eng_req) begin
        op_t o;
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R3 unexpected op got %h/%h expected none", eng_cmd, eng_tx);
          o.cmd = eng_cmd; o.tx = eng_tx; o.ack = 1'b1; o.rx = 8'h00;
        end else begin
          o = exp_q.pop_front();
          if (eng_cmd !== o.cmd || eng_tx !== o.tx) begin
            n_fail++;
            $display("FAIL R3 op got %h/%h expected %h/%h", eng_cmd, eng_tx, o.cmd, o.tx);
          end
        end
        repeat (2) @(negedge clk);
        eng_done = 1'b1; eng_ack = o.ack; eng_rx = o.rx;
        @(negedge clk);
        eng_done = 1'b0;
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic slot(input int k, input logic [7:0] v);
    wr(8'h30 + 8'(4 * k), {24'h0, v});
  endtask

  task automatic wait_idle;
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(A_ST, s);
      if (!s[0]) break;
    end
  endtask

  task automatic finish_run(input string tag, input logic [31:0] exp_st);
    logic [31:0] s;
    wait_idle();
    rd(A_ST, s);
    check({tag, " status"}, s, exp_st);
    check({tag, " R3 all ops issued"}, 32'(exp_q.size()), 32'd0);
    wr(A_ST, 32'h0000_0304);
    wr(A_GO, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(A_ST, d); check("R7 reset status", d, 32'h0);
    rd(A_CT, d); check("R10 reset ctrl", d, 32'h0);
    rd(A_DT, d); check("R5 reset data", d, 32'h0);
    check("R9 reset irq", {31'h0, irq}, 32'h0);

    // start ignored while disabled
    wr(A_GO, 32'h1);
    rd(A_GO, d); check("R2 go ignored when disabled", d, 32'h0);
    rd(A_ST, d); check("R2 not busy when disabled", d, 32'h0);

    // write program
    wr(A_CT, CT_RUN);
    slot(0, 8'h90); slot(1, 8'hA0); slot(2, 8'h10); slot(3, 8'h55);
    slot(4, 8'h50); slot(5, 8'h66);
    rd(8'h34, d); check("R1 slot readback", d, 32'h0000_00A0);
    push(8'h90, 8'hA0, 1'b1, 8'h00);
    push(8'h10, 8'h55, 1'b1, 8'h00);
    push(8'h50, 8'h66, 1'b1, 8'h00);
    wr(A_GO, 32'h1);
    rd(A_ST, d); check("R7 busy and request outstanding", d, 32'h0000_0003);
    slot(6, 8'h20);
    rd(8'h48, d); check("R1 slot write ignored while busy", d, 32'h0);
    rd(A_GO, d); check("R2 go bit reads back", d, 32'h1);
    wait_idle();
    check("R9 irq on done", {31'h0, irq}, 32'h1);
    wr(A_ST, 32'h0000_0100);
    rd(A_ST, d); check("R8 done cleared by write one", d, 32'h0006_0040);
    check("R9 irq drops after clear", {31'h0, irq}, 32'h0);
    wr(A_GO, 32'h0);
    rd(A_GO, d); check("R2 go cleared by write zero", d, 32'h0);

    // read program with packing
    slot(0, 8'h90); slot(1, 8'hA1);
    for (int k = 2; k < 7; k++) slot(k, 8'h20);
    slot(7, 8'h68);
    push(8'h90, 8'hA1, 1'b1, 8'h00);
    for (int k = 0; k < 5; k++) push(8'h20, 8'h00, 1'b1, 8'h11 + 8'(k));
    push(8'h68, 8'h00, 1'b1, 8'h16);
    wr(A_GO, 32'h1);
    finish_run("R5 read walk R4", 32'h0008_0150);
    rd(A_DT, d);        check("R5 word0 packing", d, 32'h1413_1211);
    rd(A_DT + 8'h4, d); check("R5 word1 packing", d, 32'h0000_1615);

    // full sixteen slots
    slot(0, 8'h90); slot(1, 8'hA0);
    push(8'h90, 8'hA0, 1'b1, 8'h00);
    for (int k = 1; k < 8; k++) begin
      slot(2 * k, 8'h10); slot(2 * k + 1, 8'hC0 + 8'(k));
      push(8'h10, 8'hC0 + 8'(k), 1'b1, 8'h00);
    end
    wr(A_GO, 32'h1);
    finish_run("R4 index reaches 16", 32'h0010_0110);

    // fifteen reads then a write in the last slot
    for (int k = 0; k < 15; k++) begin
      slot(k, 8'h20);
      push(8'h20, 8'h00, 1'b1, 8'hA0 + 8'(k));
    end
    slot(15, 8'h10);
    wr(A_GO, 32'h1);
    finish_run("R4 write in slot 15 ends walk", 32'h000F_0110);
    rd(A_DT + 8'h8, d); check("R5 word2 packing", d, 32'hABAA_A9A8);
    rd(A_DT + 8'hC, d); check("R5 word3 cleared at start", d, 32'h00AE_ADAC);

    // empty first slot
    slot(0, 8'h00);
    wr(A_GO, 32'h1);
    finish_run("R4 empty slot 0", 32'h0000_0110);

    // no-acknowledge abort
    slot(0, 8'h90); slot(1, 8'h42); slot(2, 8'h10); slot(3, 8'h77); slot(4, 8'h00);
    push(8'h90, 8'h42, 1'b0, 8'h00);
    push(8'h40, 8'h00, 1'b1, 8'h00);
    wr(A_GO, 32'h1);
    wait_idle();
    rd(A_ST, d); check("R6 abort flags", d, 32'h0000_0254);
    check("R9 irq on error", {31'h0, irq}, 32'h1);
    wr(A_ST, 32'h0000_0204);
    rd(A_ST, d); check("R8 error and nack cleared", d, 32'h0000_0040);
    check("R6 all ops issued", 32'(exp_q.size()), 32'd0);
    wr(A_GO, 32'h0);

    // set and clear of command done in the same cycle
    slot(1, 8'h30); slot(2, 8'h00);
    push(8'h90, 8'h30, 1'b1, 8'h00);
    wr(A_GO, 32'h1);
    @(posedge clk iff eng_done);
    wr(A_ST, 32'h0000_0100);
    wait_idle();
    rd(A_ST, d); check("R8 set wins over clear", d, 32'h0002_0110);
    wr(A_ST, 32'h0000_0100);
    rd(A_ST, d); check("R8 later clear", d, 32'h0002_0000);
    wr(A_GO, 32'h0);

    // soft reset
    wr(A_CT, 32'h1);
    rd(A_CT, d); check("R10 reset bit reads 1", {31'h0, d[0]}, 32'h1);
    repeat (8) @(negedge clk);
    rd(A_CT, d);        check("R10 ctrl after reset", d, 32'h0);
    rd(8'h34, d);       check("R10 slot cleared", d, 32'h0);
    rd(A_DT, d);        check("R10 data cleared", d, 32'h0);
    rd(A_ST, d);        check("R10 status cleared", d, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule